// File: doc/BRIEF.md
# Power Domain Gating Controller

This block switches up to three power domains off and back on under software control. Software reaches it through a simple 32-bit register port. The port has one shared request word and a small set of registers for each domain. The set holds a gating enable, a timing word for power-up and a timing word for power-down, plus a read-only status word. To start a sequence, software sets a domain's power-down or power-up request bit in the shared word. The controller then drives that domain's isolation enable and power-switch enable through a timed sequence. The request bit clears by itself when the sequence ends, so software can poll it for the power-up case.

Each sequence has two programmable phases, both counted in bus clock cycles: a lead phase and a trail phase.
- Going down, isolation is raised first, and the switch opens once both phases have elapsed.
- Going up, the switch closes first, and isolation drops once both phases have elapsed.

Each domain has its own sequencer, so the domains can run at the same time. Within one domain, a pending power-down request is served ahead of a pending power-up request.

Top module: `pwr_gate_ctl`

## Requirements
- R1: After reset, every domain is powered (power enable 1), isolation is released (0), and every implemented register reads zero.
- R2: Register map and read timing:
  - The shared request word is at byte offset 0x000.
  - The domain bases are 0x200, 0x240 and 0x260.
  - Within a domain, the gating control is at base+0x0 and uses only bit 0.
  - The power-up timing word is at base+0x4 and the power-down timing word is at base+0x8. Each timing word keeps lead in bits [5:0] and trail in bits [13:8]; all other bits read zero.
  - Read data appears on the cycle after the read access.
- R3: In the request word, the power-down bit sits at position 0, 4 or 6 for domains 0, 1 and 2, and the power-up bit is the next higher bit. Writing 1 sets a bit and writing 0 has no effect. All other bits read zero, and a bit stays set while its sequence runs.
- R4: A power-down request on a powered domain with gating enabled works as follows:
  - Isolation rises one cycle after the write.
  - The power enable falls lead+trail+2 cycles after isolation rises, using the power-down timing word.
  - The request bit clears on that same cycle.
- R5: A power-up request on an unpowered domain works as follows:
  - The power enable rises one cycle after the write.
  - Isolation falls lead+trail+2 cycles later, using the power-up timing word.
  - The request bit clears on that same cycle.
- R6: A power-down request while the gating bit is 0 changes no output and clears on the next cycle.
- R7: A request for the state the domain is already in changes no output and clears on the next cycle.
- R8: When both of a domain's request bits are set together, the power-down sequence runs first. The power-up sequence starts on the cycle after the power-down completes.
- R9: A write that sets a request bit on the same cycle its sequence completes leaves that bit set.
- R10: Status at base+0xC reads bit 0 = domain unpowered and bit 1 = sequence in progress. Writes to it are ignored.
- R11: Addresses outside the implemented registers read zero, and writes to them change nothing.
- R12: Sequences of different domains run concurrently and independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and sequencing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (10) | Byte address; bits [1:0] ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| iso_en_o | output | NUM_DOM (3) | Isolation enable per domain |
| pwr_on_o | output | NUM_DOM (3) | Power-switch enable per domain (1 = powered) |

## Verification
Two things can happen on the same clock edge: a software write that sets a request bit, and the completion clear that a sequencer issues for that bit. To provoke this, the bench gives a domain zero-length phases. It then times a second power-down write to land exactly on the edge where the first sequence opens the switch. The outcome is judged through the register port: one read a cycle later must still show the bit, and the next read must show it dropped as a no-op request. A related case is the ordering of a simultaneous power-down and power-up on one domain, which is judged from the edge-exact sequence of the switch and isolation outputs.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    localparam int DLY_W = 6;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_TRAIL
    } sq_state_e;

    typedef struct packed {
        sq_state_e         st;
        logic              dir_up;
        logic [DLY_W-1:0]  cnt;
        logic [DLY_W-1:0]  hold;
        logic              iso;
        logic              pwr;
    } sq_regs_t;

    // Byte base address of a domain's register group.
    function automatic int unsigned dom_base(input int idx);
        case (idx)
            0:       return 32'h200;
            1:       return 32'h240;
            default: return 32'h260;
        endcase
    endfunction

    // Position of a domain's power-down request bit in the shared word.
    function automatic int dn_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/pwr_gate_dec.sv
module pwr_gate_dec
    import pwr_gate_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int ADDR_W  = 10
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               gctl_hit_o,
    output logic [NUM_DOM-1:0] dom_hit_o,
    output logic [1:0]         reg_idx_o
);

    assign gctl_hit_o = (addr_i[ADDR_W-1:2] == '0);
    assign reg_idx_o  = addr_i[3:2];

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(dom_base(d));
        assign dom_hit_o[d] = (addr_i[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    end

    logic unused_byte_bits;
    assign unused_byte_bits = ^addr_i[1:0];

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
    import pwr_gate_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_dn_i,
    input  logic             go_up_i,
    input  logic [DLY_W-1:0] dn_lead_i,
    input  logic [DLY_W-1:0] dn_trail_i,
    input  logic [DLY_W-1:0] up_lead_i,
    input  logic [DLY_W-1:0] up_trail_i,
    output logic             iso_o,
    output logic             pwr_o,
    output logic             busy_o,
    output logic             fin_dn_o,
    output logic             fin_up_o
);

    sq_regs_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        fin_dn_o = 1'b0;
        fin_up_o = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (go_dn_i) begin
                    s_d.st     = SQ_LEAD;
                    s_d.dir_up = 1'b0;
                    s_d.cnt    = dn_lead_i;
                    s_d.hold   = dn_trail_i;
                    s_d.iso    = 1'b1;
                end else if (go_up_i) begin
                    s_d.st     = SQ_LEAD;
                    s_d.dir_up = 1'b1;
                    s_d.cnt    = up_lead_i;
                    s_d.hold   = up_trail_i;
                    s_d.pwr    = 1'b1;
                end
            end
            SQ_LEAD: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SQ_TRAIL;
                    s_d.cnt = s_q.hold;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SQ_TRAIL: begin
                if (s_q.cnt == '0) begin
                    s_d.st = SQ_IDLE;
                    if (s_q.dir_up) begin
                        s_d.iso  = 1'b0;
                        fin_up_o = 1'b1;
                    end else begin
                        s_d.pwr  = 1'b0;
                        fin_dn_o = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: SQ_IDLE, dir_up: 1'b0, cnt: '0, hold: '0, iso: 1'b0, pwr: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign iso_o  = s_q.iso;
    assign pwr_o  = s_q.pwr;
    assign busy_o = (s_q.st != SQ_IDLE);

    // R4
    unpowered_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_o |-> iso_o);

    // R5
    switch_on_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwr_o) |-> iso_o);

    // R8
    start_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_dn_i || go_up_i) |-> !busy_o);

endmodule

// File: rtl/pwr_gate_ctl.sv
module pwr_gate_ctl
    import pwr_gate_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int ADDR_W  = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic [NUM_DOM-1:0] iso_en_o,
    output logic [NUM_DOM-1:0] pwr_on_o
);

    typedef struct packed {
        logic [NUM_DOM-1:0]            dn_req;
        logic [NUM_DOM-1:0]            up_req;
        logic [NUM_DOM-1:0]            gate_en;
        logic [NUM_DOM-1:0][DLY_W-1:0] pu_lead;
        logic [NUM_DOM-1:0][DLY_W-1:0] pu_trail;
        logic [NUM_DOM-1:0][DLY_W-1:0] pd_lead;
        logic [NUM_DOM-1:0][DLY_W-1:0] pd_trail;
        logic [DATA_W-1:0]             rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic               gctl_hit;
    logic [NUM_DOM-1:0] dom_hit;
    logic [1:0]         reg_idx;
    logic [NUM_DOM-1:0] go_dn, go_up, drop_dn, drop_up;
    logic [NUM_DOM-1:0] busy, fin_dn, fin_up;
    logic [DATA_W-1:0]  rd_val;

    pwr_gate_dec #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W)) u_dec (
        .addr_i     (bus_addr_i),
        .gctl_hit_o (gctl_hit),
        .dom_hit_o  (dom_hit),
        .reg_idx_o  (reg_idx)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_seq
        pwr_gate_seq u_seq (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .go_dn_i    (go_dn[d]),
            .go_up_i    (go_up[d]),
            .dn_lead_i  (r_q.pd_lead[d]),
            .dn_trail_i (r_q.pd_trail[d]),
            .up_lead_i  (r_q.pu_lead[d]),
            .up_trail_i (r_q.pu_trail[d]),
            .iso_o      (iso_en_o[d]),
            .pwr_o      (pwr_on_o[d]),
            .busy_o     (busy[d]),
            .fin_dn_o   (fin_dn[d]),
            .fin_up_o   (fin_up[d])
        );
    end

    // Arbitration: power-down ahead of power-up; requests with nothing to do are dropped.
    always_comb begin
        go_dn   = '0;
        go_up   = '0;
        drop_dn = '0;
        drop_up = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (!busy[d]) begin
                if (r_q.dn_req[d]) begin
                    if (r_q.gate_en[d] && pwr_on_o[d]) go_dn[d]   = 1'b1;
                    else                               drop_dn[d] = 1'b1;
                end else if (r_q.up_req[d]) begin
                    if (!pwr_on_o[d]) go_up[d]   = 1'b1;
                    else              drop_up[d] = 1'b1;
                end
            end
        end
    end

    // Read mux.
    always_comb begin
        rd_val = '0;
        if (gctl_hit) begin
            for (int d = 0; d < NUM_DOM; d++) begin
                rd_val[dn_pos(d)]     = r_q.dn_req[d];
                rd_val[dn_pos(d) + 1] = r_q.up_req[d];
            end
        end
        for (int d = 0; d < NUM_DOM; d++) begin
            if (dom_hit[d]) begin
                case (reg_idx)
                    2'd0: rd_val[0] = r_q.gate_en[d];
                    2'd1: begin
                        rd_val[5:0]  = r_q.pu_lead[d];
                        rd_val[13:8] = r_q.pu_trail[d];
                    end
                    2'd2: begin
                        rd_val[5:0]  = r_q.pd_lead[d];
                        rd_val[13:8] = r_q.pd_trail[d];
                    end
                    default: begin
                        rd_val[0] = !pwr_on_o[d];
                        rd_val[1] = busy[d];
                    end
                endcase
            end
        end
    end

    // Next state: completion and drop clears first, then software sets (sets win).
    always_comb begin
        r_d        = r_q;
        r_d.dn_req = r_q.dn_req & ~(fin_dn | drop_dn);
        r_d.up_req = r_q.up_req & ~(fin_up | drop_up);
        if (bus_sel_i && bus_wr_i) begin
            if (gctl_hit) begin
                for (int d = 0; d < NUM_DOM; d++) begin
                    if (bus_wdata_i[dn_pos(d)])     r_d.dn_req[d] = 1'b1;
                    if (bus_wdata_i[dn_pos(d) + 1]) r_d.up_req[d] = 1'b1;
                end
            end
            for (int d = 0; d < NUM_DOM; d++) begin
                if (dom_hit[d]) begin
                    case (reg_idx)
                        2'd0: r_d.gate_en[d] = bus_wdata_i[0];
                        2'd1: begin
                            r_d.pu_lead[d]  = bus_wdata_i[5:0];
                            r_d.pu_trail[d] = bus_wdata_i[13:8];
                        end
                        2'd2: begin
                            r_d.pd_lead[d]  = bus_wdata_i[5:0];
                            r_d.pd_trail[d] = bus_wdata_i[13:8];
                        end
                        default: ;
                    endcase
                end
            end
        end
        if (bus_sel_i && !bus_wr_i) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign bus_rdata_o = r_q.rdata;

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata_i[31:14], bus_wdata_i[7:6]};

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_wr_i && !gctl_hit && dom_hit == '0) |=> bus_rdata_o == '0);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
        // R4
        iso_before_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(pwr_on_o[d]) |-> $past(iso_en_o[d]));

        // R6
        gate_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($rose(iso_en_o[d]) && pwr_on_o[d]) |-> $past(r_q.gate_en[d]));

        // R3
        req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            busy[d] |-> (r_q.dn_req[d] || r_q.up_req[d]));
    end

endmodule

// File: tb/sim_pwr_gate_ctl.sv
module sim_pwr_gate_ctl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  iso_en;
    logic [2:0]  pwr_on;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    pwr_gate_ctl u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (bus_sel),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .iso_en_o    (iso_en),
        .pwr_on_o    (pwr_on)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic outs(input string tag, input int d, input logic ei, input logic ep);
        check(tag, {30'd0, iso_en[d], pwr_on[d]}, {30'd0, ei, ep});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the access is taken at the next rising edge.
    task automatic wr(input logic [9:0] a, input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Scoreboard monitor: compares read data just after the edge that captured it.
    always @(posedge clk) begin
        #3;
        if (bus_sel && !bus_wr && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        for (int d = 0; d < 3; d++) outs("R1 outputs after reset", d, 1'b0, 1'b1);
        rd(10'h000, 32'h0, "R1 request word");
        rd(10'h200, 32'h0, "R1 gate ctl d0");
        rd(10'h244, 32'h0, "R1 pu timing d1");
        rd(10'h268, 32'h0, "R1 pd timing d2");

        // R2 map and field masks, R10 status write ignored
        wr(10'h204, 32'hFFFF_FFFF);
        rd(10'h204, 32'h0000_3F3F, "R2 pu timing field mask");
        wr(10'h200, 32'hFFFF_FFFF);
        rd(10'h200, 32'h1, "R2 gate ctl bit0 only");
        wr(10'h248, 32'h0000_0305);
        rd(10'h248, 32'h0000_0305, "R2 pd timing d1");
        wr(10'h20C, 32'hFF);
        rd(10'h20C, 32'h0, "R10 status ignores writes");

        // R11 unmapped
        wr(10'h250, 32'hFFFF);
        rd(10'h250, 32'h0, "R11 unmapped read");
        rd(10'h240, 32'h0, "R11 neighbour unchanged");
        rd(10'h3F0, 32'h0, "R11 high unmapped");
        rd(10'h2AC, 32'h0, "R11 top offset");

        // R6 gating disabled
        wr(10'h200, 32'h0);
        wr(10'h208, 32'h0);
        wr(10'h000, 32'h1);
        rd(10'h000, 32'h1, "R6 bit seen one cycle");
        rd(10'h000, 32'h0, "R6 bit dropped");
        outs("R6 outputs unchanged", 0, 1'b0, 1'b1);

        // R7 already powered
        wr(10'h000, 32'h2);
        rd(10'h000, 32'h2, "R7 bit seen one cycle");
        rd(10'h000, 32'h0, "R7 bit dropped");
        outs("R7 outputs unchanged", 0, 1'b0, 1'b1);

        // R4 power-down, lead 2 trail 1
        wr(10'h200, 32'h1);
        wr(10'h208, 32'h0102);
        wr(10'h000, 32'h1);
        outs("R4 nothing yet", 0, 1'b0, 1'b1);
        tick(1);
        outs("R4 isolation first", 0, 1'b1, 1'b1);
        tick(4);
        outs("R4 switch still on", 0, 1'b1, 1'b1);
        tick(1);
        outs("R4 switch off", 0, 1'b1, 1'b0);
        rd(10'h000, 32'h0, "R4 request cleared");

        // R5 power-up, lead 1 trail 2
        wr(10'h204, 32'h0201);
        wr(10'h000, 32'h2);
        outs("R5 nothing yet", 0, 1'b1, 1'b0);
        tick(1);
        outs("R5 switch on first", 0, 1'b1, 1'b1);
        tick(4);
        outs("R5 isolation held", 0, 1'b1, 1'b1);
        tick(1);
        outs("R5 isolation released", 0, 1'b0, 1'b1);
        rd(10'h000, 32'h0, "R5 request cleared");

        // R9 set on completion edge, zero-length phases
        wr(10'h208, 32'h0);
        wr(10'h000, 32'h1);
        tick(2);
        wr(10'h000, 32'h1);
        outs("R9 domain off", 0, 1'b1, 1'b0);
        rd(10'h000, 32'h1, "R9 set wins over clear");
        rd(10'h000, 32'h0, "R9 then dropped");
        wr(10'h000, 32'h2);
        tick(10);
        outs("R9 restored", 0, 1'b0, 1'b1);

        // R8 both bits at once on domain 1 (pd lead 5 trail 3, pu 0/0)
        wr(10'h240, 32'h1);
        wr(10'h000, 32'h30);
        tick(1);
        outs("R8 down starts", 1, 1'b1, 1'b1);
        tick(10);
        outs("R8 down done", 1, 1'b1, 1'b0);
        tick(1);
        outs("R8 up follows", 1, 1'b1, 1'b1);
        tick(2);
        outs("R8 up done", 1, 1'b0, 1'b1);
        rd(10'h000, 32'h0, "R8 requests cleared");

        // R12 / R10 concurrent domains 1 and 2
        wr(10'h260, 32'h1);
        wr(10'h268, 32'h0203);
        wr(10'h000, 32'h50);
        rd(10'h26C, 32'h0, "R10 status idle");
        rd(10'h26C, 32'h2, "R10 status busy");
        rd(10'h000, 32'h50, "R3 bits held while running");
        tick(4);
        outs("R12 d2 still on", 2, 1'b1, 1'b1);
        outs("R12 d1 still on", 1, 1'b1, 1'b1);
        tick(1);
        outs("R12 d2 off", 2, 1'b1, 1'b0);
        outs("R12 d1 running", 1, 1'b1, 1'b1);
        rd(10'h26C, 32'h1, "R10 status off");
        tick(2);
        outs("R12 d1 off", 1, 1'b1, 1'b0);
        outs("R12 d0 untouched", 0, 1'b0, 1'b1);
        rd(10'h000, 32'h0, "R12 requests cleared");

        tick(2);
        summary();
        $finish;
    end

endmodule